// File: doc/BRIEF.md
# Home-Node Directory Controller with Per-Processor Presence Bits

This block sits at the home node of a shared-memory multiprocessor. It keeps one directory entry for each memory block it owns, and it holds the block's data as well. Each entry records whether the block is cached by nobody, held read-only by one or more processors, or held writable by exactly one processor. A bit per processor marks who holds a copy. Because the holders are recorded, invalidations and recalls go only to the processors that hold copies. No message is broadcast.

Cache controllers send three kinds of request to the block: a read miss, a write miss, and the write-back of a dirty block. Each request carries the requesting processor and the block number. The controller handles one request at a time and answers with a data reply to the requester. It can also send an invalidation mask, or a recall to the current owner. The recall either leaves the owner a shared copy or takes the copy away. When a recall is outstanding, the controller stops accepting requests until the owner returns the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and all outputs marked valid are 0. Every block starts uncached with data 0, so the first read miss to any block is answered with data 0.
- R2: A read miss (`req_type`=0) to an uncached or shared block is answered one cycle after acceptance. The answer is a reply to the requester carrying the stored data, with no invalidation and no recall. Afterwards the block is shared and the requester is added to its holders.
- R3: A write miss (`req_type`=1) to an uncached block is answered one cycle later with a reply carrying the stored data. No invalidation is sent. The requester becomes the sole owner and the block becomes exclusive.
- R4: A write miss to a shared block is answered one cycle later with a reply and an invalidation mask. The mask equals the holders with the requester's bit cleared. `inv_valid` is raised only when that mask is non-zero. The requester becomes the sole owner and the block becomes exclusive.
- R5: A read miss to an exclusive block raises `fetch_valid` one cycle later, with `fetch_inv`=0 and `fetch_proc` naming the owner. When `fetch_rsp_valid` arrives, the returned data is stored. The requester then gets that data one cycle later, and the block becomes shared with both the old owner and the requester as holders.
- R6: A write miss to an exclusive block raises a recall with `fetch_inv`=1 to the old owner. The returned data is stored and forwarded to the requester one cycle after the response. The requester becomes the sole owner and the block stays exclusive.
- R7: A write-back (`req_type`=2) from the owner of an exclusive block stores `req_data`, clears all holders and makes the block uncached. It produces no output message.
- R8: A write-back from a processor that is not the owner, a write-back to a non-exclusive block, and any request with `req_type`=3 are accepted and ignored. They produce no output and change no entry.
- R9: From the cycle the recall is visible until the cycle after the owner's response, `req_ready` is 0. Requests offered in that window produce no output and change nothing. A `fetch_rsp_valid` pulse while `req_ready` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_proc | input | PID_W | Requesting processor |
| req_blk | input | BLK_W | Block number |
| req_data | input | DATA_W | Block data carried by a write-back |
| fetch_rsp_valid | input | 1 | Owner returns the recalled block |
| fetch_rsp_data | input | DATA_W | Recalled block data |
| reply_valid | output | 1 | Data reply pulse |
| reply_proc | output | PID_W | Processor receiving the reply |
| reply_data | output | DATA_W | Block data in the reply |
| inv_valid | output | 1 | Invalidation pulse |
| inv_mask | output | NUM_PROC | Processors to invalidate |
| fetch_valid | output | 1 | Recall pulse to the owner |
| fetch_inv | output | 1 | 1 when the recall also removes the owner's copy |
| fetch_proc | output | PID_W | Owner being recalled |

## Verification
The assertions assume that `fetch_rsp_valid` comes only while a recall is pending, or else is a stray pulse that the block must ignore. They also assume that requests and responses keep the in-order, one-at-a-time discipline. The stimulus drives every input half a cycle away from the rising edge. It sends a response only after a recall has been seen, and it deliberately inserts stray responses and blocked requests in the allowed windows. Random traffic is confined to a few blocks and four processors, so sharing, ownership transfer and write-backs from both owners and non-owners happen often.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 16,
  parameter int DATA_W   = 16,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_type,
  input  logic [PID_W-1:0]    req_proc,
  input  logic [BLK_W-1:0]    req_blk,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                fetch_rsp_valid,
  input  logic [DATA_W-1:0]   fetch_rsp_data,
  output logic                reply_valid,
  output logic [PID_W-1:0]    reply_proc,
  output logic [DATA_W-1:0]   reply_data,
  output logic                inv_valid,
  output logic [NUM_PROC-1:0] inv_mask,
  output logic                fetch_valid,
  output logic                fetch_inv,
  output logic [PID_W-1:0]    fetch_proc
);

  typedef enum logic [1:0] {BLK_NONE = 2'd0, BLK_SHRD = 2'd1, BLK_EXCL = 2'd2} blk_st_t;

  blk_st_t             st_q  [NUM_BLK];
  logic [NUM_PROC-1:0] hold_q[NUM_BLK];
  logic [DATA_W-1:0]   mem_q [NUM_BLK];

  logic             pend_q;
  logic             pend_wr_q;
  logic [PID_W-1:0] pend_proc_q;
  logic [BLK_W-1:0] pend_blk_q;

  function automatic logic [PID_W-1:0] first_holder(input logic [NUM_PROC-1:0] v);
    logic [PID_W-1:0] idx;
    idx = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--)
      if (v[i]) idx = PID_W'(i);
    return idx;
  endfunction

  blk_st_t             cur_st;
  logic [NUM_PROC-1:0] cur_hold;
  logic [NUM_PROC-1:0] req_bit;
  logic [NUM_PROC-1:0] pend_bit;
  logic [NUM_PROC-1:0] others;
  logic                take;

  assign req_ready = !pend_q;
  assign take      = req_valid && !pend_q;
  assign cur_st    = st_q[req_blk];
  assign cur_hold  = hold_q[req_blk];
  assign req_bit   = NUM_PROC'(1) << req_proc;
  assign pend_bit  = NUM_PROC'(1) << pend_proc_q;
  assign others    = cur_hold & ~req_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLK; b++) begin
        st_q[b]   <= BLK_NONE;
        hold_q[b] <= '0;
        mem_q[b]  <= '0;
      end
      pend_q      <= 1'b0;
      pend_wr_q   <= 1'b0;
      pend_proc_q <= '0;
      pend_blk_q  <= '0;
      reply_valid <= 1'b0;
      reply_proc  <= '0;
      reply_data  <= '0;
      inv_valid   <= 1'b0;
      inv_mask    <= '0;
      fetch_valid <= 1'b0;
      fetch_inv   <= 1'b0;
      fetch_proc  <= '0;
    end else begin
      reply_valid <= 1'b0;
      inv_valid   <= 1'b0;
      fetch_valid <= 1'b0;
      if (pend_q) begin
        if (fetch_rsp_valid) begin
          mem_q[pend_blk_q] <= fetch_rsp_data;
          reply_valid       <= 1'b1;
          reply_proc        <= pend_proc_q;
          reply_data        <= fetch_rsp_data;
          pend_q            <= 1'b0;
          if (pend_wr_q) begin
            hold_q[pend_blk_q] <= pend_bit;
            st_q[pend_blk_q]   <= BLK_EXCL;
          end else begin
            hold_q[pend_blk_q] <= hold_q[pend_blk_q] | pend_bit;
            st_q[pend_blk_q]   <= BLK_SHRD;
          end
        end
      end else if (take) begin
        case (req_type)
          2'd0, 2'd1: begin
            if (cur_st == BLK_EXCL) begin
              fetch_valid <= 1'b1;
              fetch_inv   <= req_type[0];
              fetch_proc  <= first_holder(cur_hold);
              pend_q      <= 1'b1;
              pend_wr_q   <= req_type[0];
              pend_proc_q <= req_proc;
              pend_blk_q  <= req_blk;
            end else begin
              reply_valid <= 1'b1;
              reply_proc  <= req_proc;
              reply_data  <= mem_q[req_blk];
              if (req_type[0]) begin
                inv_valid       <= (cur_st == BLK_SHRD) && (others != '0);
                inv_mask        <= (cur_st == BLK_SHRD) ? others : '0;
                hold_q[req_blk] <= req_bit;
                st_q[req_blk]   <= BLK_EXCL;
              end else begin
                hold_q[req_blk] <= cur_hold | req_bit;
                st_q[req_blk]   <= BLK_SHRD;
              end
            end
          end
          2'd2: begin
            if (cur_st == BLK_EXCL && cur_hold == req_bit) begin
              mem_q[req_blk]  <= req_data;
              hold_q[req_blk] <= '0;
              st_q[req_blk]   <= BLK_NONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module dir_home_ctrl_chk #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 16,
  parameter int DATA_W   = 16,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [1:0]          req_type,
  input logic [PID_W-1:0]    req_proc,
  input logic [BLK_W-1:0]    req_blk,
  input logic [DATA_W-1:0]   req_data,
  input logic                fetch_rsp_valid,
  input logic [DATA_W-1:0]   fetch_rsp_data,
  input logic                reply_valid,
  input logic [PID_W-1:0]    reply_proc,
  input logic [DATA_W-1:0]   reply_data,
  input logic                inv_valid,
  input logic [NUM_PROC-1:0] inv_mask,
  input logic                fetch_valid,
  input logic                fetch_inv,
  input logic [PID_W-1:0]    fetch_proc
);

  a_r4_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !inv_mask[reply_proc]);

  a_r4_inv_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (reply_valid && inv_mask != '0));

  a_r5_fetch_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !req_ready);

  a_r5_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $past(req_valid && req_ready));

  a_r6_no_reply_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !(reply_valid && fetch_valid));

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !fetch_rsp_valid) |=> !req_ready);

  a_r9_reply_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> ($past(req_valid && req_ready) || $past(fetch_rsp_valid && !req_ready)));

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
  .NUM_PROC(NUM_PROC), .NUM_BLK(NUM_BLK), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_type = '0;
  logic [1:0] req_proc = '0;
  logic [3:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic fetch_rsp_valid = 1'b0;
  logic [DW-1:0] fetch_rsp_data = '0;
  logic reply_valid;
  logic [1:0] reply_proc;
  logic [DW-1:0] reply_data;
  logic inv_valid;
  logic [NP-1:0] inv_mask;
  logic fetch_valid;
  logic fetch_inv;
  logic [1:0] fetch_proc;

  always #10 clk = ~clk;

  dir_home_ctrl #(.NUM_PROC(NP), .NUM_BLK(NB), .DATA_W(DW)) dut_i (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam int UNC = 0, SHR = 1, EXC = 2;
  int          m_st  [NB];
  logic [NP-1:0] m_shr [NB];
  logic [DW-1:0] m_mem [NB];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int first_bit(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic quiet(input string tag);
    chk(!reply_valid && !inv_valid && !fetch_valid, tag,
        {reply_valid, inv_valid, fetch_valid}, 0);
  endtask

  task automatic do_req(input int t, input int p, input int b, input logic [DW-1:0] d);
    int st;
    logic [NP-1:0] sh, pb, exp_inv;
    logic [DW-1:0] rd;
    string tag;
    st = m_st[b];
    sh = m_shr[b];
    pb = NP'(1) << p;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_proc = 2'(p); req_blk = 4'(b); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (t < 2 && st == EXC) begin
      tag = (t == 0) ? "R5" : "R6";
      chk(fetch_valid == 1'b1, tag, fetch_valid, 1);
      chk(fetch_proc == 2'(first_bit(sh)), tag, fetch_proc, first_bit(sh));
      chk(fetch_inv == (t == 1), tag, fetch_inv, t);
      chk(!reply_valid, tag, reply_valid, 0);
      chk(req_ready == 1'b0, "R9", req_ready, 0);
      if ($urandom_range(0, 2) == 0) begin
        req_valid = 1'b1; req_type = 2'($urandom_range(0, 3));
        req_proc = 2'($urandom_range(0, 3)); req_blk = 4'($urandom_range(0, 3));
        req_data = DW'($urandom);
        @(negedge clk);
        req_valid = 1'b0;
        quiet("R9");
        chk(req_ready == 1'b0, "R9", req_ready, 0);
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      rd = DW'($urandom);
      fetch_rsp_valid = 1'b1; fetch_rsp_data = rd;
      @(negedge clk);
      fetch_rsp_valid = 1'b0;
      chk(reply_valid == 1'b1, tag, reply_valid, 1);
      chk(reply_proc == 2'(p), tag, reply_proc, p);
      chk(reply_data == rd, tag, reply_data, rd);
      chk(!inv_valid && !fetch_valid, tag, {inv_valid, fetch_valid}, 0);
      chk(req_ready == 1'b1, "R9", req_ready, 1);
      m_mem[b] = rd;
      if (t == 0) begin m_shr[b] = sh | pb; m_st[b] = SHR; end
      else begin m_shr[b] = pb; m_st[b] = EXC; end
    end else if (t < 2) begin
      tag = (t == 0) ? "R2" : ((st == UNC) ? "R3" : "R4");
      exp_inv = (t == 1 && st == SHR) ? (sh & ~pb) : '0;
      chk(reply_valid == 1'b1, tag, reply_valid, 1);
      chk(reply_proc == 2'(p), tag, reply_proc, p);
      chk(reply_data == m_mem[b], tag, reply_data, m_mem[b]);
      chk(inv_valid == (exp_inv != '0), tag, inv_valid, exp_inv != '0);
      if (exp_inv != '0) chk(inv_mask == exp_inv, tag, inv_mask, exp_inv);
      chk(!fetch_valid && req_ready, tag, {fetch_valid, req_ready}, 1);
      if (t == 0) begin m_shr[b] = sh | pb; m_st[b] = SHR; end
      else begin m_shr[b] = pb; m_st[b] = EXC; end
    end else if (t == 2 && st == EXC && sh == pb) begin
      quiet("R7");
      m_mem[b] = d; m_shr[b] = '0; m_st[b] = UNC;
    end else begin
      quiet("R8");
    end
  endtask

  task automatic stray_rsp();
    @(negedge clk);
    fetch_rsp_valid = 1'b1; fetch_rsp_data = DW'($urandom);
    @(negedge clk);
    fetch_rsp_valid = 1'b0;
    quiet("R9");
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    for (int b = 0; b < NB; b++) begin m_st[b] = UNC; m_shr[b] = '0; m_mem[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    quiet("R1");
    do_req(0, 1, 9, '0);
    chk(reply_data == '0, "R1", reply_data, 0);
    do_req(0, 2, 0, '0);
    do_req(0, 1, 0, '0);
    do_req(1, 2, 0, '0);
    do_req(2, 1, 0, 16'h1111);
    do_req(0, 0, 0, '0);
    do_req(1, 3, 0, '0);
    do_req(2, 3, 0, 16'hBEEF);
    do_req(0, 2, 0, '0);
    do_req(1, 2, 0, '0);
    do_req(3, 0, 0, 16'h5555);
    do_req(2, 2, 0, 16'hCAFE);
    stray_rsp();
    do_req(0, 1, 0, '0);
    do_req(2, 1, 0, 16'h0BAD);
    do_req(0, 3, 0, '0);
    for (int i = 0; i < 3000; i++) begin
      int t, p, b;
      b = $urandom_range(0, 3);
      t = $urandom_range(0, 9);
      t = (t < 4) ? 0 : (t < 7) ? 1 : (t < 9) ? 2 : 3;
      p = $urandom_range(0, NP - 1);
      if (t == 2 && m_st[b] == EXC && $urandom_range(0, 1) == 1) p = first_bit(m_shr[b]);
      do_req(t, p, b, DW'($urandom));
      if ($urandom_range(0, 40) == 0) stray_rsp();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule